// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Stage

This stage sits between an instruction fetch unit and two integer pipelines. Each cycle the fetch unit presents two consecutive instruction words, each with its own valid flag. The stage decides whether the two can go out together. If they can, the first word goes to the primary pipe and the second to the secondary pipe. If they cannot, only the first word issues, the secondary pipe is handed a NOP, and the fetch unit is told to advance by a single word so that the second word comes back as the first word of the next pair.

The secondary pipe only does arithmetic, logical and shift work. Anything touching memory, changing control flow, trapping, multiplying, dividing or accessing processor state registers must go through the primary pipe. Pairing is also refused when the second instruction depends on the first, during an instruction-cache miss, and while the secondary pipe is disabled or not yet powered. The issue slots are registered. The fetch-advance amount is combinational, so the fetch unit can use it in the same cycle.

The instruction format is the block's own: bits [31:28] class, [27:23] destination, [22:18] first source, [17:13] second source, and bit [12] set when the second operand is an immediate. Classes 0 (add/sub), 1 (shift) and 2 (logic) are simple. Class 3 load, 4 store, 5 branch, 6 jump, 7 call, 8 trap, 9 multiply, 10 divide, 11 state read and 12 state write are primary-only, and so are 13 to 15. Classes 0, 1, 2, 3, 7, 9, 10 and 11 write the destination. The NOP word is all zeros.

Top module: `pair_issue_stage`

## Requirements
- R1: While rst_n is low and after its release, before any valid word has been captured, prim_valid and sec_valid are 0 and prim_word and sec_word are 32'h0.
- R2: When both words are valid, no cache miss is flagged, sec_enable and sec_ready are high, word 1 has a simple class (0, 1 or 2) and there is no hazard, fetch_adv is 2 in the same cycle. One clock later prim_word/sec_word hold word 0/word 1 with both valid bits set.
- R3: When word 1 has any class other than 0, 1 or 2, fetch_adv is 1. One clock later only word 0 is issued, and sec_valid is 0 with sec_word = 32'h0.
- R4: Word 0 of any class (0 to 15) issues to the primary pipe, and its class alone never prevents pairing.
- R5: Pairing is refused (fetch_adv 1) when word 0 writes a nonzero destination that word 1 reads as its first source, or as its second source when bit [12] of word 1 is 0.
- R6: Pairing is refused when both words write the same nonzero destination.
- R7: A destination of 0 in word 0 never causes a hazard.
- R8: While icache_miss is high, fetch_adv is at most 1 and the secondary slot receives the NOP one clock later.
- R9: While sec_enable or sec_ready is low, only single issue occurs. Dual issue resumes in the first cycle where both are high again.
- R10: When fetch_valid1 is low, word 0 issues alone with fetch_adv 1. When fetch_valid0 is low, nothing issues (both valid bits 0 and both words 32'h0 one clock later) and fetch_adv is 0.
- R11: When bit [12] of word 1 is set, its second source field is not compared for hazards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_word0 | input | 32 | First (older) fetched word |
| fetch_word1 | input | 32 | Second fetched word |
| fetch_valid0 | input | 1 | fetch_word0 is valid |
| fetch_valid1 | input | 1 | fetch_word1 is valid |
| icache_miss | input | 1 | Words arriving one at a time from external memory |
| sec_enable | input | 1 | Software enable for the secondary pipe |
| sec_ready | input | 1 | Secondary pipe is powered and usable |
| prim_valid | output | 1 | Primary issue slot holds an instruction |
| prim_word | output | 32 | Word for the primary pipe |
| sec_valid | output | 1 | Secondary issue slot holds an instruction |
| sec_word | output | 32 | Word for the secondary pipe (NOP when unused) |
| fetch_adv | output | 2 | Words consumed this cycle: 0, 1 or 2 |

## Verification
The bench sweeps all 256 class combinations, so a design that let a load, multiply or state access into the secondary slot would issue it there. A design that wrongly blocked on the first word's class would refetch needlessly. It sweeps a small register space over all destination and source overlaps with and without the immediate flag. A design that compared against register 0 or compared the second source under an immediate would refuse good pairs, and one that missed a dependency would pair them. All 32 combinations of miss, enable, power and valid flags are applied. Wrong priority there shows up as a paired issue during a miss or while disabled, or as a nonzero advance with an invalid first word.

// File: rtl/pair_pkg.sv
// Shared field layout, class codes and per-class properties for the
// pairing stage. Assumes the fixed 32-bit word format described in BRIEF.
package pair_pkg;
    parameter int WORD_W    = 32;
    parameter int REG_W     = 5;
    parameter int CLASS_W   = 4;
    localparam int CLS_HI   = WORD_W - 1;
    localparam int CLS_LO   = WORD_W - CLASS_W;
    localparam int RD_LO    = CLS_LO - REG_W;
    localparam int RS1_LO   = RD_LO - REG_W;
    localparam int RS2_LO   = RS1_LO - REG_W;
    localparam int IMM_BIT  = RS2_LO - 1;
    localparam logic [WORD_W-1:0] NOP_WORD = '0;

    typedef enum logic [CLASS_W-1:0] {
        CL_ADD = 4'd0, CL_SHIFT = 4'd1, CL_LOGIC = 4'd2, CL_LOAD = 4'd3,
        CL_STORE = 4'd4, CL_BRANCH = 4'd5, CL_JUMP = 4'd6, CL_CALL = 4'd7,
        CL_TRAP = 4'd8, CL_MUL = 4'd9, CL_DIV = 4'd10, CL_STRD = 4'd11,
        CL_STWR = 4'd12, CL_RSV13 = 4'd13, CL_RSV14 = 4'd14, CL_RSV15 = 4'd15
    } op_class_e;

    typedef struct packed {
        op_class_e          cls;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic               reads_rs2;
        logic               writes_rd;
        logic               simple;
    } dec_t;

    // True for classes the secondary pipe can execute.
    function automatic logic cls_simple(input logic [CLASS_W-1:0] c);
        return (c == CL_ADD) || (c == CL_SHIFT) || (c == CL_LOGIC);
    endfunction

    // True for classes that write their destination field.
    function automatic logic cls_writes(input logic [CLASS_W-1:0] c);
        case (c)
            CL_ADD, CL_SHIFT, CL_LOGIC, CL_LOAD,
            CL_CALL, CL_MUL, CL_DIV, CL_STRD: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/pair_decode.sv
// Splits one fetched word into the fields the pairing decision needs.
// Assumes the package field layout; performs no full decode.
module pair_decode
    import pair_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    // Field extraction and class properties.
    always_comb begin
        dec.cls       = op_class_e'(word[CLS_HI:CLS_LO]);
        dec.rd        = word[RD_LO +: REG_W];
        dec.rs1       = word[RS1_LO +: REG_W];
        dec.rs2       = word[RS2_LO +: REG_W];
        dec.reads_rs2 = ~word[IMM_BIT];
        dec.writes_rd = cls_writes(word[CLS_HI:CLS_LO]);
        dec.simple    = cls_simple(word[CLS_HI:CLS_LO]);
    end
endmodule

// File: rtl/pair_hazard.sv
// Detects register dependencies between the older and younger word of a
// candidate pair. Register 0 is a sink and never creates a hazard.
module pair_hazard
    import pair_pkg::*;
(
    input  dec_t older,
    input  dec_t younger,
    output logic raw,
    output logic waw
);
    logic older_wr;

    // Dependency comparisons against the older destination.
    always_comb begin
        older_wr = older.writes_rd && (older.rd != '0);
        raw = older_wr && ((younger.rs1 == older.rd) ||
                           (younger.reads_rs2 && (younger.rs2 == older.rd)));
        waw = older_wr && younger.writes_rd && (younger.rd == older.rd);
    end
endmodule

// File: rtl/pair_issue_stage.sv
// Prefetch pairing stage: chooses dual or single issue for each fetched
// pair, registers the two issue slots and reports the fetch advance
// combinationally. Assumes the fetch unit holds a pair until consumed.
module pair_issue_stage
    import pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] fetch_word0,
    input  logic [31:0] fetch_word1,
    input  logic        fetch_valid0,
    input  logic        fetch_valid1,
    input  logic        icache_miss,
    input  logic        sec_enable,
    input  logic        sec_ready,
    output logic        prim_valid,
    output logic [31:0] prim_word,
    output logic        sec_valid,
    output logic [31:0] sec_word,
    output logic [1:0]  fetch_adv
);
    localparam int SLOTS = 2;

    logic [WORD_W-1:0] words [SLOTS];
    dec_t              decs  [SLOTS];
    logic              raw_hz, waw_hz;
    logic              sec_open, pair_ok;

    assign words[0] = fetch_word0;
    assign words[1] = fetch_word1;

    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
        pair_decode u_dec (.word(words[s]), .dec(decs[s]));
    end

    pair_hazard u_hz (
        .older  (decs[0]),
        .younger(decs[1]),
        .raw    (raw_hz),
        .waw    (waw_hz)
    );

    // Pairing decision and fetch advance for the presented pair.
    always_comb begin
        sec_open  = sec_enable && sec_ready && !icache_miss;
        pair_ok   = fetch_valid0 && fetch_valid1 && sec_open &&
                    decs[1].simple && !raw_hz && !waw_hz;
        fetch_adv = !fetch_valid0 ? 2'd0 : (pair_ok ? 2'd2 : 2'd1);
    end

    // Issue slot registers, NOP when a slot is unused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_valid <= 1'b0;
            prim_word  <= NOP_WORD;
            sec_valid  <= 1'b0;
            sec_word   <= NOP_WORD;
        end else begin
            prim_valid <= fetch_valid0;
            prim_word  <= fetch_valid0 ? fetch_word0 : NOP_WORD;
            sec_valid  <= pair_ok;
            sec_word   <= pair_ok ? fetch_word1 : NOP_WORD;
        end
    end
endmodule

// File: rtl/pair_issue_chk.sv
// Temporal checks on the pairing stage ports, bound to every instance.
module pair_issue_chk
    import pair_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_valid0,
    input logic        icache_miss,
    input logic        sec_enable,
    input logic        sec_ready,
    input logic        prim_valid,
    input logic [31:0] prim_word,
    input logic        sec_valid,
    input logic [31:0] sec_word,
    input logic [1:0]  fetch_adv
);
    logic prim_wr;
    assign prim_wr = cls_writes(prim_word[CLS_HI:CLS_LO]) && (prim_word[RD_LO +: REG_W] != '0);

    // R3
    sec_simple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> cls_simple(sec_word[CLS_HI:CLS_LO]));
    // R8
    miss_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icache_miss |=> !sec_valid);
    // R9
    sec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_enable || !sec_ready) |=> !sec_valid);
    // R2
    dual_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_adv == 2'd2) |=> (prim_valid && sec_valid));
    // R10
    empty_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid0 |-> (fetch_adv == 2'd0));
    // R10
    empty_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid0 |=> (!prim_valid && !sec_valid));
    // R5
    no_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> !(prim_wr &&
            ((sec_word[RS1_LO +: REG_W] == prim_word[RD_LO +: REG_W]) ||
             (!sec_word[IMM_BIT] && (sec_word[RS2_LO +: REG_W] == prim_word[RD_LO +: REG_W])))));
    // R6
    no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> !(prim_wr && (sec_word[RD_LO +: REG_W] == prim_word[RD_LO +: REG_W])));
endmodule

bind pair_issue_stage pair_issue_chk u_pair_issue_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid0(fetch_valid0),
    .icache_miss(icache_miss), .sec_enable(sec_enable), .sec_ready(sec_ready),
    .prim_valid(prim_valid), .prim_word(prim_word), .sec_valid(sec_valid),
    .sec_word(sec_word), .fetch_adv(fetch_adv)
);

// File: tb/test_pair_issue_stage.sv
module test_pair_issue_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word0 = '0, fetch_word1 = '0;
    logic        fetch_valid0 = 1'b0, fetch_valid1 = 1'b0;
    logic        icache_miss = 1'b0, sec_enable = 1'b1, sec_ready = 1'b1;
    logic        prim_valid, sec_valid;
    logic [31:0] prim_word, sec_word;
    logic [1:0]  fetch_adv;
    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pair_issue_stage i_pair_issue_stage (
        .clk(clk), .rst_n(rst_n), .fetch_word0(fetch_word0), .fetch_word1(fetch_word1),
        .fetch_valid0(fetch_valid0), .fetch_valid1(fetch_valid1),
        .icache_miss(icache_miss), .sec_enable(sec_enable), .sec_ready(sec_ready),
        .prim_valid(prim_valid), .prim_word(prim_word), .sec_valid(sec_valid),
        .sec_word(sec_word), .fetch_adv(fetch_adv)
    );

    function automatic logic [31:0] mk(int c, int rd, int rs1, int rs2, int imm);
        return {c[3:0], rd[4:0], rs1[4:0], rs2[4:0], imm[0], 12'h000};
    endfunction

    function automatic bit is_simple(int c);
        return c <= 2;
    endfunction

    function automatic bit is_writer(int c);
        return (c <= 3) || (c == 7) || (c == 9) || (c == 10) || (c == 11);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive a pair, check the advance in-cycle and the slots one clock later.
    task automatic apply(logic [31:0] w0, logic [31:0] w1, bit v0, bit v1,
                         bit miss, bit en, bit rdy, string tag);
        int c0 = int'(w0[31:28]), c1 = int'(w1[31:28]);
        int d0 = int'(w0[27:23]), d1 = int'(w1[27:23]);
        int s1 = int'(w1[22:18]), s2 = int'(w1[17:13]);
        bit wr0 = is_writer(c0) && d0 != 0;
        bit raw = wr0 && (s1 == d0 || (!w1[12] && s2 == d0));
        bit waw = wr0 && is_writer(c1) && d1 == d0;
        bit pair = v0 && v1 && !miss && en && rdy && is_simple(c1) && !raw && !waw;
        logic [31:0] exp_adv = !v0 ? 0 : (pair ? 2 : 1);
        @(negedge clk);
        fetch_word0 = w0; fetch_word1 = w1; fetch_valid0 = v0; fetch_valid1 = v1;
        icache_miss = miss; sec_enable = en; sec_ready = rdy;
        #1;
        chk(tag, "fetch_adv", {30'd0, fetch_adv}, exp_adv);
        @(negedge clk);
        chk(tag, "prim_valid", {31'd0, prim_valid}, {31'd0, v0});
        chk(tag, "prim_word", prim_word, v0 ? w0 : 32'h0);
        chk(tag, "sec_valid", {31'd0, sec_valid}, {31'd0, pair});
        chk(tag, "sec_word", sec_word, pair ? w1 : 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "prim_valid", {31'd0, prim_valid}, 0);
        chk("R1", "sec_valid", {31'd0, sec_valid}, 0);
        chk("R1", "prim_word", prim_word, 0);
        chk("R1", "sec_word", sec_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "prim_valid after release", {31'd0, prim_valid}, 0);

        // Every class pair, registers disjoint: R2 R3 R4
        for (int c0 = 0; c0 < 16; c0++)
            for (int c1 = 0; c1 < 16; c1++)
                apply(mk(c0, 5, 1, 2, 0), mk(c1, 6, 3, 4, 0), 1, 1, 0, 1, 1,
                      !is_simple(c1) ? "R3" : (!is_simple(c0) ? "R4" : "R2"));

        // Register overlap sweep: R5 R6 R7 R11
        for (int d0 = 0; d0 < 4; d0++)
            for (int d1 = 0; d1 < 4; d1++)
                for (int a = 0; a < 4; a++)
                    for (int b = 0; b < 4; b++)
                        for (int im = 0; im < 2; im++)
                            apply(mk(0, d0, 1, 2, 0), mk(2, d1, a, b, im), 1, 1, 0, 1, 1,
                                  d0 == 0 ? "R7" :
                                  (im == 1 && b == d0) ? "R11" :
                                  (a == d0 || b == d0) ? "R5" :
                                  (d1 == d0) ? "R6" : "R2");

        // Control flag sweep: R8 R9 R10
        for (int k = 0; k < 32; k++)
            apply(mk(0, 5, 1, 2, 0), mk(1, 6, 3, 4, 1), k[0], k[1], k[2], k[3], k[4],
                  !k[0] ? "R10" : k[2] ? "R8" : (!k[3] || !k[4]) ? "R9" : !k[1] ? "R10" : "R2");

        // R9 resume: disabled, then re-enabled
        apply(mk(0, 5, 1, 2, 0), mk(1, 6, 3, 4, 0), 1, 1, 0, 0, 1, "R9");
        apply(mk(0, 5, 1, 2, 0), mk(1, 6, 3, 4, 0), 1, 1, 0, 1, 1, "R9");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule